// File: doc/BRIEF.md
# Protected System Control Register Bank

This block is a word-addressed bank of 32-bit control words for a system controller. A single request strobe carries a read or a write, a word index and write data. Read data returns one cycle later, and an error pulse in that same cycle marks an access the bank considers illegal.

A magic key written to word 0 unlocks the bank. While word 0 holds zero, any write to a higher word still takes effect but is flagged as an error.

The reset-control and boot-strap words each have a companion word. Writing the main word ORs bits in. Writing the companion word clears bits in the main word. For the strap words, the OR path is frozen whenever a protect word is nonzero.

Some words have fixed behaviour:
- Three words are read-only.
- Three PLL status words always read back with their lock bit set.
- One data word returns a fresh pseudo-random value on every read. The value comes from an internal LFSR.

All addresses below are word indices, which are byte offsets divided by four.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the bank holds these values:
  - word 16 = 0xF7CFFFDC, word 20 = 0xFFFFFFFC, word 32 = 0xEFF43E8B, word 36 = 0xFFF0FFF0, word 128 = 0x1000405F;
  - words 1 and 5 = `siliconRev`, word 320 = `strap0Init`, word 324 = `strap1Init`, word 0 = `lockInit`;
  - every other word = 0.
- R2: The read data of a read request appears on `rdata` in the cycle after the request. `rdata` is 0 after reset and holds its value when no read is made. `err` is high only in the cycle after an illegal access.
- R3: The window spans word indices 0 to 903. A read at index 904 or above returns 0 and pulses `err`. A write there changes nothing and pulses `err`; this includes indices whose low bits alias an in-range word.
- R4: Writing 0x1688A8A8 to word 0 stores 1 there. Writing any other value stores 0. A write to word 0 never raises `err` on its own.
- R5: A write to any in-range word above 0 while word 0 is zero pulses `err`. The write is still carried out according to the kind of the addressed word.
- R6: Writes to words 16 and 20 OR the data into the word. Writes to words 17 and 21 clear the set data bits in words 16 and 20 respectively. Words 17 and 21 read back as 0.
- R7: Words 320 and 324 are straps that a write ORs into. The write is ignored while word 322 (for strap 320) or word 326 (for strap 324) is nonzero. Writes to words 321 and 325 clear bits in words 320 and 324 whatever the protect words hold. The protect words are plain storage.
- R8: Words 1, 5 and 336 are read-only. A write to them is discarded and pulses `err`.
- R9: Reads of words 129, 137 and 145 return the stored value with bit 31 set to 1.
- R10: Each read of word 336 steps an LFSR and returns its new state. The LFSR is 0x00000001 after reset, and its next state is (s>>1) XOR (s[0] ? 0xA3000000 : 0). The behaviour does not depend on the content of word 329.
- R11: Every other in-range word is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (12) | Word index |
| wdata | input | 32 | Write data |
| siliconRev | input | 32 | Revision loaded into words 1 and 5 at reset |
| strap0Init | input | 32 | Reset value of strap word 320 |
| strap1Init | input | 32 | Reset value of strap word 324 |
| lockInit | input | 32 | Reset value of lock word 0 |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle illegal-access pulse |

## Verification
The bench runs the bank from two resets, one locked and one unlocked. It compares every cycle against a behavioural word-array model.

Each word kind gets its own test:
- Writes while locked are compared with writes after the key, which separates the error flag from the store itself.
- The set and clear pairs are tried with overlapping and disjoint bit masks, which shows the clear lands on the word below.
- Strap writes are tried with the protect word cleared, set, then cleared again, which shows that only the OR path freezes.
- Out-of-range writes at indices that alias word 50 in their low bits tell a real range check from plain truncation.
- Repeated random reads, made with word 329 both cleared and set, tell stepping on each read from a free-running or gated source.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1688A8A8;
  localparam logic [DATA_W-1:0] PLL_LOCK_BIT = 32'h80000000;

  // word indices whose behaviour is special
  localparam int IX_LOCK = 0;
  localparam int IX_REV_A = 1;
  localparam int IX_REV_B = 5;
  localparam int IX_RST_A = 16;
  localparam int IX_RST_A_CLR = 17;
  localparam int IX_RST_B = 20;
  localparam int IX_RST_B_CLR = 21;
  localparam int IX_GATE_A = 32;
  localparam int IX_GATE_B = 36;
  localparam int IX_PLL_CFG = 128;
  localparam int IX_PLL_X = 129;
  localparam int IX_PLL_Y = 137;
  localparam int IX_PLL_Z = 145;
  localparam int IX_STRAP_A = 320;
  localparam int IX_STRAP_A_CLR = 321;
  localparam int IX_STRAP_A_PROT = 322;
  localparam int IX_STRAP_B = 324;
  localparam int IX_STRAP_B_CLR = 325;
  localparam int IX_STRAP_B_PROT = 326;
  localparam int IX_RNG = 336;

  typedef struct packed {
    logic wrKey;
    logic wrPlain;
    logic wrOr;
    logic wrAndNot;
    logic rdLoad;
    logic rdZero;
    logic rdPll;
    logic rdRng;
    logic errNow;
  } strobe_t;

  function automatic logic [DATA_W-1:0] baseValue(input int idx);
    case (idx)
      IX_RST_A:   return 32'hF7CFFFDC;
      IX_RST_B:   return 32'hFFFFFFFC;
      IX_GATE_A:  return 32'hEFF43E8B;
      IX_GATE_B:  return 32'hFFF0FFF0;
      IX_PLL_CFG: return 32'h1000405F;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] TAPS = 32'hA3000000,
  parameter logic [W-1:0] SEED = 32'h00000001
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         step,
  output logic [W-1:0] nextState
);
  logic [W-1:0] state;

  assign nextState = state[0] ? ((state >> 1) ^ TAPS) : (state >> 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEED;
    else if (step) state <= nextState;
  end
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int WORDS = 904,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             req,
  input  logic             we,
  input  logic [ADDR_W-1:0] addr,
  input  logic             lockOpen,
  input  logic             protASet,
  input  logic             protBSet,
  output strobe_t          stb,
  output logic [IDX_W-1:0] tgtIdx,
  output logic [IDX_W-1:0] rdIdx
);
  logic             inRange;
  logic [IDX_W-1:0] idx;

  assign inRange = addr < ADDR_W'(WORDS);
  assign idx = addr[IDX_W-1:0];
  assign rdIdx = idx;

  always_comb begin
    stb = '0;
    tgtIdx = idx;
    if (req && !inRange) begin
      stb.errNow = 1'b1;
      stb.rdLoad = !we;
      stb.rdZero = !we;
    end else if (req && !we) begin
      stb.rdLoad = 1'b1;
      stb.rdRng = (idx == IDX_W'(IX_RNG));
      stb.rdPll = (idx == IDX_W'(IX_PLL_X)) || (idx == IDX_W'(IX_PLL_Y)) ||
                  (idx == IDX_W'(IX_PLL_Z));
    end else if (req && we) begin
      stb.errNow = (idx != IDX_W'(IX_LOCK)) && !lockOpen;
      case (idx)
        IDX_W'(IX_LOCK): stb.wrKey = 1'b1;
        IDX_W'(IX_REV_A), IDX_W'(IX_REV_B), IDX_W'(IX_RNG): stb.errNow = 1'b1;
        IDX_W'(IX_RST_A), IDX_W'(IX_RST_B): stb.wrOr = 1'b1;
        IDX_W'(IX_STRAP_A): stb.wrOr = !protASet;
        IDX_W'(IX_STRAP_B): stb.wrOr = !protBSet;
        IDX_W'(IX_RST_A_CLR), IDX_W'(IX_RST_B_CLR),
        IDX_W'(IX_STRAP_A_CLR), IDX_W'(IX_STRAP_B_CLR): begin
          stb.wrAndNot = 1'b1;
          tgtIdx = idx - IDX_W'(1);
        end
        default: stb.wrPlain = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int WORDS = 904,
  parameter logic [DATA_W-1:0] RNG_SEED = 32'h00000001,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  tgtIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] siliconRev,
  input  logic [DATA_W-1:0] strap0Init,
  input  logic [DATA_W-1:0] strap1Init,
  input  logic [DATA_W-1:0] lockInit,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              lockOpen,
  output logic              protASet,
  output logic              protBSet
);
  logic [DATA_W-1:0] regs [WORDS];
  logic [DATA_W-1:0] rngNext;

  sysctl_lfsr #(.W(DATA_W), .SEED(RNG_SEED)) u_rng (
    .clk(clk), .rstN(rstN), .step(stb.rdRng), .nextState(rngNext)
  );

  assign lockOpen = regs[IX_LOCK] != '0;
  assign protASet = regs[IX_STRAP_A_PROT] != '0;
  assign protBSet = regs[IX_STRAP_B_PROT] != '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) regs[i] <= baseValue(i);
      regs[IX_REV_A] <= siliconRev;
      regs[IX_REV_B] <= siliconRev;
      regs[IX_STRAP_A] <= strap0Init;
      regs[IX_STRAP_B] <= strap1Init;
      regs[IX_LOCK] <= lockInit;
    end else begin
      if (stb.wrKey) regs[IX_LOCK] <= (wdata == UNLOCK_KEY) ? 32'd1 : 32'd0;
      if (stb.wrPlain) regs[tgtIdx] <= wdata;
      if (stb.wrOr) regs[tgtIdx] <= regs[tgtIdx] | wdata;
      if (stb.wrAndNot) regs[tgtIdx] <= regs[tgtIdx] & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
      err <= 1'b0;
    end else begin
      err <= stb.errNow;
      if (stb.rdLoad) begin
        if (stb.rdZero) rdata <= '0;
        else if (stb.rdRng) rdata <= rngNext;
        else if (stb.rdPll) rdata <= regs[rdIdx] | PLL_LOCK_BIT;
        else rdata <= regs[rdIdx];
      end
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int WORDS = 904,
  parameter int ADDR_W = 12,
  parameter logic [31:0] RNG_SEED = 32'h00000001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       siliconRev,
  input  logic [31:0]       strap0Init,
  input  logic [31:0]       strap1Init,
  input  logic [31:0]       lockInit,
  output logic [31:0]       rdata,
  output logic              err
);
  localparam int IDX_W = $clog2(WORDS);

  strobe_t          stb;
  logic [IDX_W-1:0] tgtIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             lockOpen;
  logic             protASet;
  logic             protBSet;

  sysctl_ctrl #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_ctrl (
    .req(req), .we(we), .addr(addr), .lockOpen(lockOpen),
    .protASet(protASet), .protBSet(protBSet),
    .stb(stb), .tgtIdx(tgtIdx), .rdIdx(rdIdx)
  );

  sysctl_dp #(.WORDS(WORDS), .RNG_SEED(RNG_SEED)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtIdx(tgtIdx), .rdIdx(rdIdx),
    .wdata(wdata), .siliconRev(siliconRev), .strap0Init(strap0Init),
    .strap1Init(strap1Init), .lockInit(lockInit), .rdata(rdata), .err(err),
    .lockOpen(lockOpen), .protASet(protASet), .protBSet(protBSet)
  );
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int WORDS = 904,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              err
);
  logic rdReq;
  logic oob;
  assign rdReq = req && !we;
  assign oob = addr >= ADDR_W'(WORDS);

  // R2: error pulses only follow an access
  a_r2_err_after_req: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $past(req));
  // R2: read data held without a read
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(rdata));
  // R3: out-of-range access flagged
  a_r3_oob_err: assert property (@(posedge clk) disable iff (!rstN)
    (req && oob) |=> err);
  // R3: out-of-range read returns zero
  a_r3_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && oob) |=> (rdata == 32'd0));
  // R8: write to a read-only word flagged
  a_r8_ro_err: assert property (@(posedge clk) disable iff (!rstN)
    (req && we && (addr == ADDR_W'(1) || addr == ADDR_W'(5) || addr == ADDR_W'(336))) |=> err);
  // R9: PLL words report lock
  a_r9_pll_lock: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && (addr == ADDR_W'(129) || addr == ADDR_W'(137) || addr == ADDR_W'(145))) |=> rdata[31]);
  // R10: random word never zero
  a_r10_rng_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && addr == ADDR_W'(336)) |=> (rdata != 32'd0));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .rdata(rdata), .err(err)
);

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
  localparam int WORDS = 904;
  localparam int ADDR_W = 12;
  localparam logic [31:0] KEY = 32'h1688A8A8;

  logic clk = 0;
  logic rstN = 0;
  logic req = 0, we = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] siliconRev = 32'h05000303;
  logic [31:0] strap0Init = 32'h000000F0;
  logic [31:0] strap1Init = 32'h12340000;
  logic [31:0] lockInit = 32'h0;
  logic [31:0] rdata;
  logic err;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [31:0] model [WORDS];
  logic [31:0] rngM;
  logic [31:0] expRd;

  always #5 clk = ~clk;

  sysctl_regbank #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_sysctl_regbank (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .siliconRev(siliconRev), .strap0Init(strap0Init), .strap1Init(strap1Init),
    .lockInit(lockInit), .rdata(rdata), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [31:0] key);
    @(negedge clk);
    lockInit = key;
    rstN = 0;
    req = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    for (int i = 0; i < WORDS; i++) model[i] = 32'h0;
    model[16] = 32'hF7CFFFDC; model[20] = 32'hFFFFFFFC;
    model[32] = 32'hEFF43E8B; model[36] = 32'hFFF0FFF0; model[128] = 32'h1000405F;
    model[1] = siliconRev; model[5] = siliconRev;
    model[320] = strap0Init; model[324] = strap1Init; model[0] = key;
    rngM = 32'h1;
    expRd = 32'h0;
    check(rdata == 32'h0, "R2 rdata after reset", rdata, 32'h0);
    check(err == 1'b0, "R2 err after reset", {31'h0, err}, 32'h0);
  endtask

  // one access, checked in the following cycle
  task automatic op(input bit w, input int a, input logic [31:0] d, input string tag);
    bit expErr = 0;
    req = 1; we = w; addr = a[ADDR_W-1:0]; wdata = d;
    if (a >= WORDS) begin
      expErr = 1;
      if (!w) expRd = 32'h0;
    end else if (w) begin
      expErr = (a != 0) && (model[0] == 32'h0);
      case (a)
        0: model[0] = (d == KEY) ? 32'h1 : 32'h0;
        1, 5, 336: expErr = 1;
        16, 20: model[a] = model[a] | d;
        320, 324: if (model[a+2] == 32'h0) model[a] = model[a] | d;
        17, 21, 321, 325: model[a-1] = model[a-1] & ~d;
        default: model[a] = d;
      endcase
    end else begin
      case (a)
        336: begin
          rngM = rngM[0] ? ((rngM >> 1) ^ 32'hA3000000) : (rngM >> 1);
          expRd = rngM;
        end
        129, 137, 145: expRd = model[a] | 32'h80000000;
        default: expRd = model[a];
      endcase
    end
    @(negedge clk);
    req = 0;
    check(rdata == expRd, $sformatf("%s rdata a=%0d", tag, a), rdata, expRd);
    check(err == expErr, $sformatf("%s err a=%0d", tag, a), {31'h0, err}, {31'h0, expErr});
  endtask

  task automatic idle(input string tag);
    req = 0;
    @(negedge clk);
    check(rdata == expRd, tag, rdata, expRd);
    check(err == 1'b0, tag, {31'h0, err}, 32'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    doReset(32'h0);
    // R1 reset contents
    foreach (model[i]) if (i < 0) $display("unused");
    op(0, 0, 0, "R1"); op(0, 1, 0, "R1"); op(0, 5, 0, "R1");
    op(0, 16, 0, "R1"); op(0, 20, 0, "R1"); op(0, 32, 0, "R1");
    op(0, 36, 0, "R1"); op(0, 128, 0, "R1"); op(0, 320, 0, "R1");
    op(0, 324, 0, "R1"); op(0, 50, 0, "R1"); op(0, 903, 0, "R1");
    op(0, 17, 0, "R6 clear word reads zero");
    idle("R2 hold");
    idle("R2 hold");
    // R5 locked writes flag but apply
    op(1, 50, 32'hCAFE0001, "R5 locked write");
    op(0, 50, 0, "R5 readback");
    // R4 key
    op(1, 0, 32'h1688A8A9, "R4 wrong key");
    op(0, 0, 0, "R4 readback");
    op(1, 0, KEY, "R4 key");
    op(0, 0, 0, "R4 readback");
    op(1, 50, 32'h00000077, "R11 plain write");
    op(0, 50, 0, "R11 readback");
    // R6 set/clear pairs
    op(1, 16, 32'h00000023, "R6 set");
    op(0, 16, 0, "R6");
    op(1, 17, 32'hF0000021, "R6 clear");
    op(0, 16, 0, "R6");
    op(0, 17, 0, "R6");
    op(1, 21, 32'h0000FFFF, "R6 clear");
    op(1, 20, 32'h00000101, "R6 set");
    op(0, 20, 0, "R6");
    op(0, 21, 0, "R6");
    // R7 straps
    op(1, 320, 32'h00000F00, "R7 set");
    op(0, 320, 0, "R7");
    op(1, 322, 32'h1, "R7 protect");
    op(1, 320, 32'hFFFF0000, "R7 blocked set");
    op(0, 320, 0, "R7 unchanged");
    op(1, 321, 32'h000000F0, "R7 clear while protected");
    op(0, 320, 0, "R7");
    op(0, 322, 0, "R7 protect readback");
    op(1, 322, 32'h0, "R7 unprotect");
    op(1, 320, 32'hA0000000, "R7 set again");
    op(0, 320, 0, "R7");
    op(1, 326, 32'h80000000, "R7 protect B");
    op(1, 324, 32'h0000000F, "R7 blocked B");
    op(1, 325, 32'h12000000, "R7 clear B");
    op(0, 324, 0, "R7 B");
    op(1, 326, 32'h0, "R7 unprotect B");
    op(1, 324, 32'h0000000F, "R7 set B");
    op(0, 324, 0, "R7 B");
    // R8 read-only
    op(1, 1, 32'hFFFFFFFF, "R8 ro");
    op(1, 5, 32'h0, "R8 ro");
    op(1, 336, 32'h12345678, "R8 ro");
    op(0, 1, 0, "R8"); op(0, 5, 0, "R8");
    // R9 PLL lock bit
    op(0, 129, 0, "R9");
    op(1, 129, 32'h00001234, "R9 write");
    op(0, 129, 0, "R9");
    op(1, 137, 32'h7FFFFFFF, "R9 write");
    op(0, 137, 0, "R9");
    op(0, 145, 0, "R9");
    // R10 random word
    for (int k = 0; k < 4; k++) op(0, 336, 0, "R10");
    idle("R10 no step when idle");
    op(1, 329, 32'h0, "R10 disable");
    op(0, 336, 0, "R10 disabled");
    op(0, 336, 0, "R10 disabled");
    op(1, 329, 32'h1, "R10 enable");
    op(0, 336, 0, "R10");
    // R3 out of range
    op(0, 904, 0, "R3 oob read");
    op(0, 1023, 0, "R3 oob read");
    op(0, 4095, 0, "R3 oob read");
    op(1, 904, 32'hDEADBEEF, "R3 oob write");
    op(1, 1024 + 50, 32'hDEADBEEF, "R3 aliasing write");
    op(0, 50, 0, "R3 alias untouched");
    op(0, 903, 0, "R3 last word");
    op(1, 903, 32'h5A5A5A5A, "R11 last word");
    op(0, 903, 0, "R11");
    // relock
    op(1, 0, 32'h1, "R4 relock");
    op(1, 60, 32'h3, "R5 locked again");
    op(0, 60, 0, "R5");
    // second reset unlocked
    doReset(32'h1);
    op(0, 0, 0, "R1 lock loads input");
    op(1, 60, 32'h9, "R5 open after reset");
    op(0, 60, 0, "R11");
    op(0, 336, 0, "R10 seed restart");
    op(0, 336, 0, "R10");
    idle("R2 hold");
    finished = 1;
    summary();
    $finish;
  end
endmodule